// File: doc/BRIEF.md
# Segmented Address Translation Checker

This block turns a segment selector and a 32-bit offset into a 32-bit linear address. On the way it enforces the protection rules attached to the selected segment. The selector chooses one entry from one of two on-chip descriptor tables. The global table is shared by every task. The local table belongs to the running task. A host loads both tables through a one-entry-per-cycle write port.

Each access arrives on a valid/ready request channel, together with the requester's current privilege level. The block reads the descriptor in the first cycle. In the second cycle it evaluates the index range, presence, privilege and bounds checks, and it forms the sum. The result then waits on a valid/ready response channel until the requester takes it. A faulting access returns a single fault code and no address.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits [15:3] are the table index. Bit 2 picks the table: 0 for global and 1 for local. Bits [1:0] have no effect on the result.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored at entry `wr_index` of the table chosen by `wr_local` (0 global, 1 local). A write to an index at or beyond that table's depth changes no entry.
- R3: The descriptor layout is as follows. Bits [31:0] hold the base. Bits [51:32] hold an inclusive byte limit. Bits [54:53] hold the privilege level. Bit 55 is the present bit. All other bits are ignored.
- R4: A permitted access returns the base plus the offset, taken modulo 2^32, with fault code 0 (none).
- R5: An index at or beyond the selected table's depth returns fault code 1 (index).
- R6: A descriptor whose present bit is 0 returns fault code 2 (absent).
- R7: A current privilege number greater than the descriptor's privilege number returns fault code 3 (privilege). An equal or smaller number is permitted.
- R8: An offset greater than the limit returns fault code 4 (limit). An offset equal to the limit is permitted.
- R9: When several checks fail, only one code is reported. The order is index, then absent, then privilege, then limit, and the code always lies in 0..4.
- R10: Whenever the fault code is nonzero, `rsp_addr` is 0.
- R11: A request is accepted at an edge where `req_valid` and `req_ready` are both high. `rsp_valid` rises at the second edge after acceptance. `req_ready` stays low from acceptance until the response is taken.
- R12: While `rsp_valid` is high and `rsp_ready` is low, the response holds its value. After an edge with both high, `rsp_valid` is low and `req_ready` is high.
- R13: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_local | input | 1 | Write target: 0 global, 1 local |
| wr_index | input | 13 | Entry written |
| wr_data | input | 64 | Descriptor contents |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_sel | input | 16 | Segment selector |
| req_offset | input | 32 | Offset within the segment |
| req_cpl | input | 2 | Requester's current privilege level |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_addr | output | 32 | Linear address, 0 on a fault |
| rsp_fault | output | 3 | 0 none, 1 index, 2 absent, 3 privilege, 4 limit |

## Verification
The bench builds the block with a global table depth of 16 and a local table depth of 8. With these depths, the first out-of-range index of each table can be reached in a single selector. The last global entry is loaded with a base near the top of the address space, so the wrap of the sum can be tested. A write aimed past the end of the global table would alias onto a live entry if the range check failed, and a later read of that entry exposes it. The response hold and release behaviour is driven with a requester that withholds `rsp_ready` for several cycles.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int SEL_W  = 16;
  localparam int IDX_W  = 13;
  localparam int OFF_W  = 32;
  localparam int DESC_W = 64;
  localparam int LIM_W  = 20;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_INDEX  = 3'd1,
    FLT_ABSENT = 3'd2,
    FLT_PRIV   = 3'd3,
    FLT_LIMIT  = 3'd4
  } fault_e;

  typedef struct packed {
    logic             present;
    logic [1:0]       dpl;
    logic [LIM_W-1:0] limit;
    logic [OFF_W-1:0] base;
  } desc_t;

  function automatic desc_t unpack_desc(input logic [DESC_W-1:0] raw);
    desc_t d;
    d.base    = raw[31:0];
    d.limit   = raw[51:32];
    d.dpl     = raw[54:53];
    d.present = raw[55];
    return d;
  endfunction

  function automatic logic [OFF_W-1:0] linear_of(input logic [OFF_W-1:0] base,
                                                 input logic [OFF_W-1:0] off);
    return base + off;
  endfunction

  function automatic logic within_limit(input logic [OFF_W-1:0] off,
                                        input logic [LIM_W-1:0] limit);
    return off <= {{(OFF_W-LIM_W){1'b0}}, limit};
  endfunction

  function automatic fault_e pick_fault(input logic       idx_ok,
                                        input desc_t      d,
                                        input logic [1:0] cpl,
                                        input logic [OFF_W-1:0] off);
    if (!idx_ok)                     return FLT_INDEX;
    if (!d.present)                  return FLT_ABSENT;
    if (cpl > d.dpl)                 return FLT_PRIV;
    if (!within_limit(off, d.limit)) return FLT_LIMIT;
    return FLT_NONE;
  endfunction

endpackage

// File: rtl/seg_desc_ram.sv
module seg_desc_ram
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DESC_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DESC_W-1:0] rd_data,
  output logic              rd_hit
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W:0] DEPTH_L = DEPTH[IDX_W:0];

  logic [DESC_W-1:0] mem [DEPTH];

  logic wr_in_range;
  logic rd_in_range;
  assign wr_in_range = {1'b0, wr_idx} < DEPTH_L;
  assign rd_in_range = {1'b0, rd_idx} < DEPTH_L;

  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) mem[wr_idx[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_hit <= rd_in_range;
      if (rd_in_range) rd_data <= mem[rd_idx[AW-1:0]];
      else             rd_data <= '0;
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
(
  input  logic [DESC_W-1:0] raw_desc,
  input  logic              idx_ok,
  input  logic [1:0]        cpl,
  input  logic [OFF_W-1:0]  offset,
  output logic [OFF_W-1:0]  lin_addr,
  output fault_e            fault
);

  desc_t d;

  always_comb begin
    d     = unpack_desc(raw_desc);
    fault = pick_fault(idx_ok, d, cpl, offset);
    if (fault == FLT_NONE) lin_addr = linear_of(d.base, offset);
    else                   lin_addr = '0;
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int GDT_DEPTH = 64,
  parameter int LDT_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_local,
  input  logic [12:0] wr_index,
  input  logic [63:0] wr_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_sel,
  input  logic [31:0] req_offset,
  input  logic [1:0]  req_cpl,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_addr,
  output logic [2:0]  rsp_fault
);

  localparam int NTAB = 2;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_HOLD} state_e;
  state_e st;

  // selector fields
  logic [IDX_W-1:0] sel_idx;
  logic             sel_local;
  logic [1:0]       unused_rpl;
  assign sel_idx    = req_sel[15:3];
  assign sel_local  = req_sel[2];
  assign unused_rpl = req_sel[1:0];

  // named events
  logic accept;
  logic look_done;
  logic rsp_take;
  assign accept    = req_valid && (st == S_IDLE);
  assign look_done = (st == S_LOOK);
  assign rsp_take  = (st == S_HOLD) && rsp_ready;

  // captured request
  logic [OFF_W-1:0] q_off;
  logic [1:0]       q_cpl;
  logic             q_local;

  logic [DESC_W-1:0] tab_data [NTAB];
  logic              tab_hit  [NTAB];

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    localparam int D = (t == 0) ? GDT_DEPTH : LDT_DEPTH;
    logic tab_wr;
    logic tab_rd;
    assign tab_wr = wr_en  && (wr_local  == t[0]);
    assign tab_rd = accept && (sel_local == t[0]);
    seg_desc_ram #(.DEPTH(D)) u_ram (
      .clk     (clk),
      .wr_en   (tab_wr),
      .wr_idx  (wr_index),
      .wr_data (wr_data),
      .rd_en   (tab_rd),
      .rd_idx  (sel_idx),
      .rd_data (tab_data[t]),
      .rd_hit  (tab_hit[t])
    );
  end

  logic [DESC_W-1:0] cur_desc;
  logic              cur_hit;
  assign cur_desc = q_local ? tab_data[1] : tab_data[0];
  assign cur_hit  = q_local ? tab_hit[1]  : tab_hit[0];

  logic [OFF_W-1:0] chk_addr;
  fault_e           chk_fault;

  seg_check u_check (
    .raw_desc (cur_desc),
    .idx_ok   (cur_hit),
    .cpl      (q_cpl),
    .offset   (q_off),
    .lin_addr (chk_addr),
    .fault    (chk_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      q_off     <= '0;
      q_cpl     <= '0;
      q_local   <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          q_off   <= req_offset;
          q_cpl   <= req_cpl;
          q_local <= sel_local;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          rsp_addr  <= chk_addr;
          rsp_fault <= chk_fault;
          st        <= S_HOLD;
        end
        S_HOLD: if (rsp_take) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_HOLD);

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_addr,
  input logic [2:0]  rsp_fault,
  input logic        accept,
  input logic        look_done
);

  // R11
  acc_to_look_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> look_done && !rsp_valid && !req_ready);

  // R11
  look_to_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    look_done |=> rsp_valid);

  // R11
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R12
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));

  // R12
  resp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready && !rsp_valid);

  // R10
  zero_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 3'd0) |-> rsp_addr == 32'd0);

  // R9
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault <= 3'd4);

endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_fault (rsp_fault),
  .accept    (accept),
  .look_done (look_done)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_local;
  logic [12:0] wr_index;
  logic [63:0] wr_data;
  logic        req_valid, req_ready;
  logic [15:0] req_sel;
  logic [31:0] req_offset;
  logic [1:0]  req_cpl;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_addr;
  logic [2:0]  rsp_fault;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  seg_xlate #(.GDT_DEPTH(16), .LDT_DEPTH(8)) u_seg_xlate (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // descriptor: [31:0] base, [51:32] limit, [54:53] level, [55] present (R3)
  function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                     input logic [1:0] lvl, input logic p);
    return {8'h00, p, lvl, 1'b0, lim, base};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit loc, input logic [12:0] idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_local = loc; wr_index = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // issue one request, take the response; returns address and fault
  task automatic xfer(input logic [15:0] sel, input logic [31:0] off, input logic [1:0] cpl,
                      output logic [31:0] a, output logic [2:0] f);
    @(negedge clk);
    req_valid = 1; req_sel = sel; req_offset = off; req_cpl = cpl;
    @(negedge clk);
    req_valid = 0;
    // R11: one edge after acceptance no result yet
    check(!rsp_valid && !req_ready, "R11", {30'd0, rsp_valid, req_ready}, 32'd0);
    @(negedge clk);
    check(rsp_valid, "R11", {31'd0, rsp_valid}, 32'd1);
    a = rsp_addr; f = rsp_fault;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    // R12: released
    check(req_ready && !rsp_valid, "R12", {30'd0, req_ready, rsp_valid}, 32'd2);
  endtask

  // {sel, offset, cpl, exp_addr, exp_fault}
  localparam int NV = 17;
  localparam logic [84:0] VEC [NV] = '{
    {16'h0000, 32'h0000_0010, 2'd0, 32'h0001_0010, 3'd0}, // R4
    {16'h0000, 32'h0000_0FFF, 2'd0, 32'h0001_0FFF, 3'd0}, // R8 equal to limit
    {16'h0000, 32'h0000_1000, 2'd0, 32'h0000_0000, 3'd4}, // R8
    {16'h0000, 32'h0000_0000, 2'd1, 32'h0000_0000, 3'd3}, // R7
    {16'h0008, 32'h0001_2345, 2'd3, 32'h8001_2345, 3'd0}, // R7 equal level
    {16'h0010, 32'h0000_0000, 2'd0, 32'h0000_0000, 3'd2}, // R6
    {16'h0010, 32'h0000_0100, 2'd3, 32'h0000_0000, 3'd2}, // R9 absent first
    {16'h0080, 32'h0000_0000, 2'd0, 32'h0000_0000, 3'd1}, // R5 global 16
    {16'h0044, 32'hFFFF_0000, 2'd3, 32'h0000_0000, 3'd1}, // R9 local 8
    {16'h0004, 32'h0000_00FF, 2'd1, 32'h0040_00FF, 3'd0}, // R1 local table
    {16'h0004, 32'h0000_0080, 2'd2, 32'h0000_0000, 3'd3}, // R7 local
    {16'h003C, 32'h0000_0000, 2'd3, 32'h1234_0000, 3'd0}, // R8 zero limit
    {16'h003C, 32'h0000_0001, 2'd0, 32'h0000_0000, 3'd4}, // R8
    {16'h0078, 32'h0000_01FF, 2'd3, 32'h0000_00FF, 3'd0}, // R4 wrap
    {16'h000B, 32'h0000_0010, 2'd0, 32'h8000_0010, 3'd0}, // R1 low bits
    {16'h0020, 32'h0000_0000, 2'd0, 32'h0ABC_0000, 3'd0}, // R2 no alias
    {16'h0000, 32'h0000_5000, 2'd1, 32'h0000_0000, 3'd3}  // R9 priv over limit
  };

  initial begin
    string vtag [NV];
    logic [31:0] a;
    logic [2:0]  f;
    vtag = '{"R4", "R8", "R8", "R7", "R7", "R6", "R9", "R5", "R9",
             "R1", "R7", "R8", "R8", "R4", "R1", "R2", "R9"};
    rst_n = 0; wr_en = 0; wr_local = 0; wr_index = 0; wr_data = 0;
    req_valid = 0; req_sel = 0; req_offset = 0; req_cpl = 0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    // R13
    check(!rsp_valid && req_ready, "R13", {30'd0, rsp_valid, req_ready}, 32'd1);
    rst_n = 1;

    wr(0, 13'd0,  mk(32'h0001_0000, 20'h00FFF, 2'd0, 1'b1));
    wr(0, 13'd1,  mk(32'h8000_0000, 20'hFFFFF, 2'd3, 1'b1));
    wr(0, 13'd2,  mk(32'h0000_2000, 20'h00010, 2'd2, 1'b0));
    wr(0, 13'd4,  mk(32'h0ABC_0000, 20'h00010, 2'd0, 1'b1));
    wr(0, 13'd20, mk(32'hDEAD_0000, 20'hFFFFF, 2'd0, 1'b1)); // R2 beyond depth
    wr(0, 13'd15, mk(32'hFFFF_FF00, 20'h00200, 2'd3, 1'b1));
    wr(1, 13'd0,  mk(32'h0040_0000, 20'h000FF, 2'd1, 1'b1));
    wr(1, 13'd7,  {8'hFF, 1'b1, 2'd3, 1'b1, 20'h00000, 32'h1234_0000}); // R3 spare bits set

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][84:69], VEC[i][68:37], VEC[i][36:35], a, f);
      check(a == VEC[i][34:3], vtag[i], a, VEC[i][34:3]);
      check(f == VEC[i][2:0], vtag[i], {29'd0, f}, {29'd0, VEC[i][2:0]});
      check(f == 3'd0 || a == 32'd0, "R10", a, 32'd0);
    end

    // R12: hold under backpressure
    @(negedge clk);
    req_valid = 1; req_sel = 16'h0008; req_offset = 32'h77; req_cpl = 2'd2;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(rsp_valid && !req_ready, "R12", {30'd0, rsp_valid, req_ready}, 32'd2);
      check(rsp_addr == 32'h8000_0077 && rsp_fault == 3'd0, "R12", rsp_addr, 32'h8000_0077);
      @(negedge clk);
    end
    // R11: request ignored while busy
    req_valid = 1; req_sel = 16'h0000; req_offset = 0; req_cpl = 0;
    @(negedge clk);
    check(rsp_addr == 32'h8000_0077, "R11", rsp_addr, 32'h8000_0077);
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(req_ready && !rsp_valid, "R12", {30'd0, req_ready, rsp_valid}, 32'd2);

    // R2: rewrite a global entry, read back through the request port
    wr(0, 13'd4, mk(32'h0000_0300, 20'h00010, 2'd1, 1'b1));
    xfer(16'h0020, 32'h10, 2'd1, a, f);
    check(a == 32'h0000_0310 && f == 3'd0, "R2", a, 32'h0000_0310);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule